// File: doc/BRIEF.md
# Simultaneous Multithreading Fetch Thread Selector

The selector runs once per cycle inside the front end of a core that keeps several hardware threads in flight. It decides which threads may fetch from the instruction cache in the next cycle. It has `X` grant slots and gives them out in priority order. Each granted thread may fetch up to `Y` instructions. The instruction cache, the fetch buffers and the per-thread counters sit outside the block. The selector only reads the counters and produces the grant list.

A policy input picks how threads are ranked:
- **Plain rotation.** Threads are ranked by rotation only.
- **Occupancy.** The thread with the fewest instructions in the pipeline goes first.
- **Unresolved branches.** The thread with the fewest unresolved branches goes first.
- **Outstanding misses.** The thread with the fewest outstanding cache misses goes first.
- **Queue age.** Threads whose oldest instruction sits near the head of the issue queue are pushed down.

A rotating pointer decides every tie. The pointer moves one past the last thread granted, so no runnable thread is left waiting for ever. A thread with its runnable bit clear is never granted. The grant list is registered and appears one clock after its inputs are sampled.

Top module: `fetch_thread_picker`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no thread runnable, every `grant_vld` bit is 0 and every `grant_budget` is 0.
- R2: With policy code 0 (rotation), slot 0 gets the first runnable thread at or after the rotation pointer, counting upward modulo N. Slot 1 gets the next such thread, and so on. When at least X threads are runnable, exactly X slots are valid.
- R3: With policy code 1, runnable threads are granted in ascending order of `inflight_cnt`, so the thread with the fewest pending instructions is in slot 0.
- R4: With policy code 2, runnable threads are granted in ascending order of `branch_cnt`.
- R5: With policy code 3, runnable threads are granted in ascending order of `miss_cnt`.
- R6: With policy code 4, runnable threads are granted in descending order of `oldest_pos`. Position 0 is the head of the issue queue, so a thread holding the oldest instruction at the head ranks last.
- R7: Threads with equal keys are ordered by distance from the rotation pointer, (tid − ptr) mod N, smallest first. The pointer resets to 0. After each cycle with any grant it moves to one past the thread in the highest valid slot, modulo N. It is unchanged after a cycle with no grant.
- R8: A thread whose `runnable` bit is 0 is never granted, whatever its counter values.
- R9: The grant outputs change only at a clock edge. They reflect the inputs present just before that edge.
- R10: When fewer than X threads are runnable, the valid slots are filled from slot 0 upward. The remaining slots have `grant_vld` = 0 and `grant_budget` = 0.
- R11: No thread appears in two valid slots in the same cycle, and every valid slot carries a budget of exactly Y.
- R12: Policy codes 5, 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 3 | Ranking policy code |
| runnable | input | N | Bit t set when thread t may fetch |
| inflight_cnt | input | N*CW | Per-thread count of instructions in the pipeline, thread t at bits t*CW |
| branch_cnt | input | N*CW | Per-thread count of unresolved branches |
| miss_cnt | input | N*CW | Per-thread count of outstanding cache misses |
| oldest_pos | input | N*CW | Per-thread issue-queue position of the oldest instruction, 0 = head |
| grant_tid | output | X*TW | Thread id in each slot, slot 0 = highest priority |
| grant_vld | output | X | Slot holds a granted thread |
| grant_budget | output | X*BW | Instructions the slot's thread may fetch |

## Verification
The tie-break rotation and the count ranking act in the same cycle whenever two runnable threads carry equal keys. The same grant that resolves the tie also moves the pointer used by the next cycle's tie-breaks. The bench makes ties common by drawing counters from a small range. It also runs directed cycles with all keys equal under a count policy. A reference model keeps its own pointer and orders threads by key, then by rotation distance. Each cycle's slot list is compared with that model, so a pointer that moves wrongly shows up in the following cycle's order.

// File: rtl/fetch_thread_picker.sv
`timescale 1ns/1ps
module fetch_thread_picker #(
  parameter int N  = 8,
  parameter int X  = 2,
  parameter int Y  = 4,
  parameter int CW = 6,
  localparam int TW = $clog2(N),
  localparam int BW = $clog2(Y + 1),
  localparam int RW = CW + TW
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      policy,
  input  logic [N-1:0]    runnable,
  input  logic [N*CW-1:0] inflight_cnt,
  input  logic [N*CW-1:0] branch_cnt,
  input  logic [N*CW-1:0] miss_cnt,
  input  logic [N*CW-1:0] oldest_pos,
  output logic [X*TW-1:0] grant_tid,
  output logic [X-1:0]    grant_vld,
  output logic [X*BW-1:0] grant_budget
);

  localparam logic [2:0] POL_INFL = 3'd1;
  localparam logic [2:0] POL_BR   = 3'd2;
  localparam logic [2:0] POL_MISS = 3'd3;
  localparam logic [2:0] POL_AGE  = 3'd4;

  logic [TW-1:0]   rr_ptr, nxt_ptr;
  logic [CW-1:0]   key   [N];
  logic [RW-1:0]   rank  [N];
  logic [TW:0]     place [N];
  logic [X-1:0]    nxt_vld;
  logic [X*TW-1:0] nxt_tid;
  logic            started;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      int d;
      case (policy)
        POL_INFL: key[i] = inflight_cnt[i*CW +: CW];
        POL_BR:   key[i] = branch_cnt[i*CW +: CW];
        POL_MISS: key[i] = miss_cnt[i*CW +: CW];
        POL_AGE:  key[i] = ~oldest_pos[i*CW +: CW];
        default:  key[i] = '0;
      endcase
      d = i - int'(rr_ptr);
      if (d < 0) d = d + N;
      rank[i] = {key[i], TW'(d)};
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      int c;
      c = 0;
      for (int j = 0; j < N; j++)
        if (runnable[j] && rank[j] < rank[i]) c = c + 1;
      place[i] = (TW+1)'(c);
    end
  end

  always_comb begin
    nxt_vld = '0;
    nxt_tid = '0;
    for (int s = 0; s < X; s++)
      for (int i = 0; i < N; i++)
        if (runnable[i] && place[i] == (TW+1)'(s)) begin
          nxt_vld[s] = 1'b1;
          nxt_tid[s*TW +: TW] = TW'(i);
        end
    nxt_ptr = rr_ptr;
    for (int s = 0; s < X; s++)
      if (nxt_vld[s])
        nxt_ptr = (nxt_tid[s*TW +: TW] == TW'(N-1)) ? '0 : nxt_tid[s*TW +: TW] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr    <= '0;
      grant_vld <= '0;
      grant_tid <= '0;
      started   <= 1'b0;
    end else begin
      rr_ptr    <= nxt_ptr;
      grant_vld <= nxt_vld;
      grant_tid <= nxt_tid;
      started   <= 1'b1;
    end
  end

  for (genvar s = 0; s < X; s++) begin : g_slot
    assign grant_budget[s*BW +: BW] = grant_vld[s] ? BW'(Y) : '0;

    AST_ONLY_RUNNABLE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld[s] |-> ((($past(runnable) >> grant_tid[s*TW +: TW]) & N'(1)) != '0)); // R8

    if (s > 0) begin : g_pack
      AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld[s] |-> grant_vld[s-1]); // R10
    end

    for (genvar u = s + 1; u < X; u++) begin : g_pair
      AST_NO_DUP_TID: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld[s] && grant_vld[u]) |-> (grant_tid[s*TW +: TW] != grant_tid[u*TW +: TW])); // R11
    end
  end

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ($countones(grant_vld) ==
      (($countones($past(runnable)) >= X) ? X : $countones($past(runnable))))); // R2

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (started && grant_vld == '0) |-> $stable(rr_ptr)); // R7

endmodule

// File: tb/fetch_thread_picker_test.sv
`timescale 1ns/1ps
module fetch_thread_picker_test;
  localparam int N = 8, X = 2, Y = 4, CW = 6;
  localparam int TW = $clog2(N), BW = $clog2(Y + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] policy = '0;
  logic [N-1:0] runnable = '0;
  logic [N*CW-1:0] infl = '0, brc = '0, msc = '0, qps = '0;
  logic [X*TW-1:0] grant_tid;
  logic [X-1:0] grant_vld;
  logic [X*BW-1:0] grant_budget;

  int checks = 0, fails = 0;
  int mptr = 0;
  int exp_tid [X];
  bit exp_vld [X];
  int exp_ptr;

  always #10 clk = ~clk;

  fetch_thread_picker #(.N(N), .X(X), .Y(Y), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .policy(policy), .runnable(runnable),
    .inflight_cnt(infl), .branch_cnt(brc), .miss_cnt(msc), .oldest_pos(qps),
    .grant_tid(grant_tid), .grant_vld(grant_vld), .grant_budget(grant_budget));

  function automatic string tag_of(input logic [2:0] p);
    case (p)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R12";
    endcase
  endfunction

  function automatic int key_of(input int t);
    case (policy)
      3'd1: return int'(infl[t*CW +: CW]);
      3'd2: return int'(brc[t*CW +: CW]);
      3'd3: return int'(msc[t*CW +: CW]);
      3'd4: return (1 << CW) - 1 - int'(qps[t*CW +: CW]);
      default: return 0;
    endcase
  endfunction

  task automatic predict();
    bit taken [N];
    for (int t = 0; t < N; t++) taken[t] = 0;
    exp_ptr = mptr;
    for (int s = 0; s < X; s++) begin
      int best;
      best = -1;
      for (int k = 0; k < N; k++) begin
        int t;
        t = (mptr + k) % N;
        if (runnable[t] && !taken[t])
          if (best < 0 || key_of(t) < key_of(best)) best = t;
      end
      exp_vld[s] = (best >= 0);
      exp_tid[s] = (best >= 0) ? best : 0;
      if (best >= 0) begin
        taken[best] = 1;
        exp_ptr = (best + 1) % N;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string extra);
    string tg;
    tg = tag_of(policy);
    predict();
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < X; s++) begin
      chk(grant_vld[s] == exp_vld[s], exp_vld[s] ? tg : "R10", $sformatf("R9 vld slot%0d %s", s, extra),
          int'(grant_vld[s]), int'(exp_vld[s]));
      chk(int'(grant_budget[s*BW +: BW]) == (exp_vld[s] ? Y : 0), "R11", $sformatf("budget slot%0d", s),
          int'(grant_budget[s*BW +: BW]), exp_vld[s] ? Y : 0);
      if (exp_vld[s])
        chk(int'(grant_tid[s*TW +: TW]) == exp_tid[s], tg, $sformatf("R7 R8 tid slot%0d %s", s, extra),
            int'(grant_tid[s*TW +: TW]), exp_tid[s]);
    end
    mptr = exp_ptr;
  endtask

  task automatic set_all(ref logic [N*CW-1:0] v, input int val);
    for (int t = 0; t < N; t++) v[t*CW +: CW] = CW'(val);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(grant_vld == '0, "R1", "vld in reset", int'(grant_vld), 0);
    chk(grant_budget == '0, "R1", "budget in reset", int'(grant_budget), 0);
    rst_n = 1'b1;
    step("R1 idle after reset");

    // rotation, all runnable: pointer walks 0,2,4,6,0
    policy = 3'd0; runnable = '1;
    for (int k = 0; k < 5; k++) step("R2 rotate");

    // occupancy with distinct counts
    policy = 3'd1;
    for (int t = 0; t < N; t++) infl[t*CW +: CW] = CW'(20 - t * 2);
    step("R3 distinct");

    // equal keys under count policy: pure rotation tie-break
    set_all(brc, 5); policy = 3'd2;
    for (int k = 0; k < 4; k++) step("R7 tie");

    // miss count and queue age
    policy = 3'd3;
    for (int t = 0; t < N; t++) msc[t*CW +: CW] = CW'((t * 5) % 7);
    step("R5 directed");
    policy = 3'd4;
    for (int t = 0; t < N; t++) qps[t*CW +: CW] = CW'((t * 3) % 8);
    step("R6 directed");

    // nonrunnable with best counts ignored
    policy = 3'd1; set_all(infl, 30);
    infl[0 +: CW] = '0; infl[CW +: CW] = '0;
    runnable = 8'b1111_1100;
    step("R8 masked best");

    // fewer than X runnable, then none
    runnable = 8'b0010_0000; step("R10 one");
    runnable = '0; step("R10 none");
    runnable = '0; step("R7 ptr hold");
    runnable = 8'b1000_0001; policy = 3'd6; step("R12 wrap");

    // random mix with small counters to force ties
    for (int n = 0; n < 400; n++) begin
      policy = 3'($urandom_range(0, 7));
      for (int t = 0; t < N; t++) begin
        runnable[t] = ($urandom_range(0, 3) != 0);
        infl[t*CW +: CW] = CW'($urandom_range(0, 3));
        brc[t*CW +: CW]  = CW'($urandom_range(0, 3));
        msc[t*CW +: CW]  = CW'($urandom_range(0, 3));
        qps[t*CW +: CW]  = CW'($urandom_range(0, 63));
      end
      step("random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule